// File: doc/BRIEF.md
# Macro-Tile Channel and Bank Selector

This unit takes an unsigned pixel coordinate (x, y) for a surface laid out in two-dimensional macro tiles and reports which memory channel and which memory bank hold that pixel. Both indices are XOR hashes of a few low coordinate bits. The y bit positions used for the bank shift upward by log2 of the channel count. A mode input adds one more x term to the most significant bank bit.

The configuration comes with each request: a channel count, a bank count and the alternate-bank flag. The result goes through one pipeline register with a valid/ready handshake, so that a downstream address composer can apply backpressure. Byte offsets, the order of pixels inside a tile and memory access are handled elsewhere.

Top module: `tile_hash_unit`

## Requirements
- R1: For a channel count of 2, or any count other than 4 and 8, out_chan[0] = x[3]^y[3] and out_chan[2:1] = 0.
- R2: For a channel count of 4, out_chan[0] = x[4]^y[3], out_chan[1] = x[3]^y[4] and out_chan[2] = 0.
- R3: For a channel count of 8, out_chan[0] = x[5]^y[3], out_chan[1] = x[4]^x[5]^y[4] and out_chan[2] = x[3]^y[5].
- R4: For a bank count of 4 with the flag low, out_bank[0] = x[3]^y[4+cb], out_bank[1] = x[4]^y[3+cb] and out_bank[2] = 0. cb is defined in R8.
- R5: For a bank count of 8 with the flag low, out_bank[0] = x[3]^y[5+cb], out_bank[1] = x[4]^y[4+cb]^y[5+cb] and out_bank[2] = x[5]^y[3+cb].
- R6: With the alternate-bank flag high, the top bank bit also takes an x term: out_bank[1] ^= x[5] for 4 banks, and out_bank[2] ^= x[6] for 8 banks.
- R7: Any bank count other than 4 or 8 gives out_bank = 0.
- R8: cb is the index of the highest set bit of the channel count, and 0 when the count is 0. A count of 3 gives 1 and a count of 1 gives 0. A y index at or above the coordinate width reads as 0.
- R9: A request accepted when in_valid and in_ready are both high appears on the outputs, with out_valid high, on the next clock edge.
- R10: While out_valid is high and out_ready is low, in_ready is low and out_valid, out_chan and out_bank hold. in_ready is high whenever out_valid is low or out_ready is high.
- R11: A synchronous active-high reset clears out_valid, out_chan and out_bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_x | input | 14 | Pixel x coordinate |
| in_y | input | 14 | Pixel y coordinate |
| chan_count | input | 4 | Number of memory channels (2, 4 or 8) |
| bank_count | input | 4 | Number of memory banks (4 or 8) |
| alt_bank | input | 1 | Selects the alternate bank equation |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_chan | output | 3 | Channel index |
| out_bank | output | 3 | Bank index |

## Verification
Single-bit x and y coordinates are applied for every channel count, bank count and flag setting. A swapped or misplaced hash term then shows up as a single wrong index bit. Channel counts of 3, 1 and 0 check the fallback channel equation and the log2 used for the bank bits; a design that treated them as exact powers of two would move the bank y terms. Bank counts outside 4 and 8 check that the bank is forced to zero rather than falling back to an equation. Random backpressure checks that a stalled result is held and not overwritten by new input, and that a result is not shown twice after it has been taken.

// File: rtl/tile_hash_pkg.sv
package tile_hash_pkg;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic [IDX_W-1:0] chan;
    logic [IDX_W-1:0] bank;
  } hash_t;

  localparam int HASH_W = $bits(hash_t);
endpackage

// File: rtl/tile_chan_hash.sv
module tile_chan_hash #(
  parameter int COORD_W = 14,
  parameter int CNT_W   = 4
) (
  input  logic [COORD_W-1:0]             x,
  input  logic [COORD_W-1:0]             y,
  input  logic [CNT_W-1:0]               count,
  output logic [tile_hash_pkg::IDX_W-1:0] chan
);
  always_comb begin
    chan = '0;
    if (count == CNT_W'(4)) begin
      chan[0] = x[4] ^ y[3];
      chan[1] = x[3] ^ y[4];
    end else if (count == CNT_W'(8)) begin
      chan[0] = x[5] ^ y[3];
      chan[1] = x[4] ^ x[5] ^ y[4];
      chan[2] = x[3] ^ y[5];
    end else begin
      chan[0] = x[3] ^ y[3];
    end
  end
endmodule

// File: rtl/tile_bank_hash.sv
module tile_bank_hash #(
  parameter int COORD_W = 14,
  parameter int CNT_W   = 4,
  parameter int CB_W    = 2
) (
  input  logic [COORD_W-1:0]             x,
  input  logic [COORD_W-1:0]             y,
  input  logic [CNT_W-1:0]               count,
  input  logic [CB_W-1:0]                cb,
  input  logic                           alt,
  output logic [tile_hash_pkg::IDX_W-1:0] bank
);
  function automatic logic ybit(input logic [COORD_W-1:0] v, input int idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < COORD_W; i++)
      if (i == idx) r = v[i];
    return r;
  endfunction

  int sh;
  logic y3, y4, y5;

  always_comb begin
    sh = int'(cb);
    y3 = ybit(y, 3 + sh);
    y4 = ybit(y, 4 + sh);
    y5 = ybit(y, 5 + sh);
    bank = '0;
    if (count == CNT_W'(4)) begin
      bank[0] = x[3] ^ y4;
      bank[1] = x[4] ^ y3 ^ (alt & x[5]);
    end else if (count == CNT_W'(8)) begin
      bank[0] = x[3] ^ y5;
      bank[1] = x[4] ^ y4 ^ y5;
      bank[2] = x[5] ^ y3 ^ (alt & x[6]);
    end
  end
endmodule

// File: rtl/tile_hash_stage.sv
module tile_hash_stage #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tile_hash_unit.sv
module tile_hash_unit #(
  parameter int COORD_W = 14,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [CNT_W-1:0]   chan_count,
  input  logic [CNT_W-1:0]   bank_count,
  input  logic               alt_bank,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2:0]         out_chan,
  output logic [2:0]         out_bank
);
  import tile_hash_pkg::*;

  localparam int CB_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

  logic [CB_W-1:0] cb;
  hash_t           nxt, cur;

  always_comb begin
    cb = '0;
    for (int i = 0; i < CNT_W; i++)
      if (chan_count[i]) cb = CB_W'(i);
  end

  tile_chan_hash #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_chan (
    .x(in_x), .y(in_y), .count(chan_count), .chan(nxt.chan)
  );

  tile_bank_hash #(.COORD_W(COORD_W), .CNT_W(CNT_W), .CB_W(CB_W)) u_bank (
    .x(in_x), .y(in_y), .count(bank_count), .cb(cb), .alt(alt_bank),
    .bank(nxt.bank)
  );

  tile_hash_stage #(.DW(HASH_W)) u_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(nxt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(cur)
  );

  assign out_chan = cur.chan;
  assign out_bank = cur.bank;
endmodule

// File: rtl/tile_hash_chk.sv
module tile_hash_chk #(
  parameter int COORD_W = 14,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [COORD_W-1:0] in_x,
  input logic [COORD_W-1:0] in_y,
  input logic [CNT_W-1:0]   chan_count,
  input logic [CNT_W-1:0]   bank_count,
  input logic               alt_bank,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2:0]         out_chan,
  input logic [2:0]         out_bank
);
  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !out_valid && out_chan == 3'd0 && out_bank == 3'd0);

  // R9
  accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_bank));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R1
  narrow_chan_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && chan_count != 4'd4 && chan_count != 4'd8
    |=> out_chan[2:1] == 2'b00);

  // R7
  bad_bank_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && bank_count != 4'd4 && bank_count != 4'd8
    |=> out_bank == 3'd0);

  // R4
  four_bank_top_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && bank_count == 4'd4 |=> !out_bank[2]);
endmodule

bind tile_hash_unit tile_hash_chk #(.COORD_W(COORD_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/tile_hash_unit_test.sv
module tile_hash_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_x = '0;
  logic [13:0] in_y = '0;
  logic [3:0]  chan_count = 4'd2;
  logic [3:0]  bank_count = 4'd4;
  logic        alt_bank = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_chan;
  logic [2:0]  out_bank;

  int checks = 0;
  int fails  = 0;

  // model state
  int    m_valid = 0;
  int    m_chan  = 0;
  int    m_bank  = 0;
  string m_ctag  = "R11";
  string m_btag  = "R11";

  always #5 clk = ~clk;

  tile_hash_unit uut (.*);

  function automatic int bitof(int v, int k);
    return (v >> k) & 1;
  endfunction

  function automatic int ref_chan(int x, int y, int cc);
    if (cc == 4)
      return (bitof(x,4) ^ bitof(y,3)) | ((bitof(x,3) ^ bitof(y,4)) << 1);
    if (cc == 8)
      return (bitof(x,5) ^ bitof(y,3)) |
             ((bitof(x,4) ^ bitof(x,5) ^ bitof(y,4)) << 1) |
             ((bitof(x,3) ^ bitof(y,5)) << 2);
    return bitof(x,3) ^ bitof(y,3);
  endfunction

  function automatic int ref_bank(int x, int y, int cc, int bc, int alt);
    int cb = 0;
    int n = cc;
    while (n > 1) begin n = n >> 1; cb++; end
    if (bc == 4)
      return (bitof(x,3) ^ bitof(y,4+cb)) |
             ((bitof(x,4) ^ bitof(y,3+cb) ^ (alt & bitof(x,5))) << 1);
    if (bc == 8)
      return (bitof(x,3) ^ bitof(y,5+cb)) |
             ((bitof(x,4) ^ bitof(y,4+cb) ^ bitof(y,5+cb)) << 1) |
             ((bitof(x,5) ^ bitof(y,3+cb) ^ (alt & bitof(x,6))) << 2);
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic iv, input int x, input int y,
                      input int cc, input int bc, input logic alt, input logic ordy);
    int rdy;
    @(negedge clk);
    check(m_valid != 0 ? "R9 out_valid" : "R9/R11 out_valid", int'(out_valid), m_valid);
    if (m_valid != 0) begin
      check(m_ctag, int'(out_chan), m_chan);
      check(m_btag, int'(out_bank), m_bank);
    end else if (rst) begin
      check("R11 chan", int'(out_chan), 0);
      check("R11 bank", int'(out_bank), 0);
    end
    rst = r; in_valid = iv; in_x = 14'(x); in_y = 14'(y);
    chan_count = 4'(cc); bank_count = 4'(bc); alt_bank = alt; out_ready = ordy;
    #1;
    rdy = (m_valid == 0 || ordy) ? 1 : 0;
    check("R10 in_ready", int'(in_ready), rdy);
    if (r) begin
      m_valid = 0; m_chan = 0; m_bank = 0;
    end else if (iv && rdy != 0) begin
      m_valid = 1;
      m_chan  = ref_chan(x, y, cc);
      m_bank  = ref_bank(x, y, cc, bc, int'(alt));
      m_ctag  = (cc == 4) ? "R2 chan" : (cc == 8) ? "R3 chan" : "R1 chan";
      if (bc != 4 && bc != 8)              m_btag = "R7 bank";
      else if (alt)                        m_btag = "R6 bank";
      else if (cc != 2 && cc != 4 && cc != 8) m_btag = "R8 bank";
      else if (bc == 4)                    m_btag = "R4 bank";
      else                                 m_btag = "R5 bank";
    end else if (ordy) begin
      m_valid = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int ccs[6] = '{2, 4, 8, 3, 1, 0};
    int bcs[3] = '{4, 8, 5};
    // reset with traffic present (R11)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8, 8, 8, 8, 1'b1, 1'b1);
    step(1'b0, 1'b0, 0, 0, 2, 4, 1'b0, 1'b1);
    // directed single-bit coordinates over every configuration
    foreach (ccs[a])
      foreach (bcs[b])
        for (int alt = 0; alt < 2; alt++)
          for (int k = 0; k < 14; k++) begin
            step(1'b0, 1'b1, 1 << k, 0, ccs[a], bcs[b], alt[0], 1'b1);
            step(1'b0, 1'b1, 0, 1 << k, ccs[a], bcs[b], alt[0], 1'b1);
          end
    step(1'b0, 1'b1, 16383, 16383, 8, 8, 1'b1, 1'b1);
    // random traffic with backpressure
    for (int i = 0; i < 4000; i++) begin
      int cc = (($urandom % 4) == 0) ? int'($urandom % 16) : (2 << ($urandom % 3));
      int bc = (($urandom % 5) == 0) ? int'($urandom % 16) : (4 << ($urandom % 2));
      step(1'b0, 1'($urandom % 4 != 0), int'($urandom % 16384), int'($urandom % 16384),
           cc, bc, 1'($urandom), 1'($urandom % 3 != 0));
    end
    // mid-run reset (R11)
    step(1'b0, 1'b1, 127, 127, 8, 8, 1'b0, 1'b0);
    step(1'b1, 1'b1, 127, 127, 8, 8, 1'b0, 1'b0);
    step(1'b0, 1'b0, 0, 0, 2, 4, 1'b0, 1'b1);
    step(1'b0, 1'b0, 0, 0, 2, 4, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule